// File: doc/BRIEF.md
# SPI Frame Command Sequencer

This block runs the byte-level control of one framed SPI transaction. A 32-bit command word, written while the block is idle, names a chip-select line, the frame length, an optional receive-skip count and two mode flags. For each byte, the sequencer decides whether the byte shifter takes its data from the transmit FIFO or from a generated zero. It also decides whether the byte clocked back in is pushed into the receive FIFO. It holds the selected chip select low for the whole frame and pulses a done event once the last byte has been shifted.

The bit shifter and both FIFOs sit outside the block. The sequencer gives the shifter a one-cycle start strobe per byte and waits for a one-cycle completion strobe. It pops the transmit FIFO together with the start strobe and pushes the receive FIFO together with the completion strobe. A byte is not started while the data it needs is missing or the space it needs is not available. In receive-skip mode the frame splits into two phases. The first phase sends command bytes and keeps no received data. The second phase shifts zeros and keeps every received byte, and it can optionally raise a dual-line output indication.

Top module: `spi_frame_seq`

## Requirements
- R1: After reset the block is idle: `busy` low, every `cs_n` line high, and `shift_go`, `tx_pop`, `tx_zero`, `rx_push`, `dual_o` and `done` low.
- R2: A command accepted while idle makes `busy` high, and command bits 31:30 pick the chip select: `cs_n[sel]` alone is low from the cycle after acceptance until the frame ends. A select code of `NUM_CS` or above drives no line low, but the frame still runs.
- R3: The low `LEN_W` bits of the command hold the frame length minus one, and exactly that many plus one byte starts occur. With all ones, the frame is the maximum of 2**LEN_W bytes (65536 by default).
- R4: With skip count 0 and bit 27 clear, every byte pops the transmit FIFO and every received byte is pushed.
- R5: With skip count 0 and bit 27 (transmit-only) set, every byte pops the transmit FIFO and nothing is pushed.
- R6: With a nonzero skip count N in bits 23:16, the first N bytes each pop the transmit FIFO (`tx_pop`), and their received data is dropped. Bit 27 has no effect in this mode.
- R7: In skip mode, each byte after the first N uses generated zero data (`tx_zero`, no pop), and its received byte is pushed. When N is at least the frame length, every byte pops and none is pushed.
- R8: `dual_o` is high only during the zero phase of a skip-mode frame whose bit 28 is set. With a skip count of 0, bit 28 has no effect.
- R9: No byte starts that needs transmit data while `tx_empty` is high.
- R10: No byte starts whose received data must be kept while `rx_full` is high.
- R11: `done` is a one-cycle pulse in the cycle the last byte's completion strobe arrives. `busy` is low on the following cycle and all `cs_n` lines are high.
- R12: A command presented while busy is ignored. Chip select, byte count and data sources of the running frame are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word |
| tx_empty | input | 1 | Transmit FIFO holds no byte |
| rx_full | input | 1 | Receive FIFO has no free entry |
| shift_done | input | 1 | Shifter finished the current byte |
| busy | output | 1 | A frame is in progress |
| cs_n | output | NUM_CS | Chip-select lines, active low |
| shift_go | output | 1 | Start strobe for one byte |
| tx_pop | output | 1 | Byte data taken from the transmit FIFO |
| tx_zero | output | 1 | Byte data is a generated zero |
| rx_push | output | 1 | Store the received byte in the receive FIFO |
| dual_o | output | 1 | Dual-line output phase indication |
| done | output | 1 | Frame complete pulse |

## Verification
The bench builds the block with `NUM_CS` = 3 and `LEN_W` = 6. The three-line select leaves code 3 unmatched, so the path where no chip select is asserted can be exercised. The 6-bit length field makes the maximum 64-byte frame and its all-ones encoding cheap to run. Skip counts below, equal to and above the frame length all fit within that range, so both phase boundaries and the fully skipped frame are reached many times over.

// File: rtl/spi_frame_seq_pkg.sv
package spi_frame_seq_pkg;

   // command word field positions
   localparam int SEL_HI     = 31;
   localparam int SEL_LO     = 30;
   localparam int DUAL_BIT   = 28;
   localparam int TXONLY_BIT = 27;
   localparam int SKIP_HI    = 23;
   localparam int SKIP_LO    = 16;
   localparam int SEL_W      = SEL_HI - SEL_LO + 1;
   localparam int SKIP_W     = SKIP_HI - SKIP_LO + 1;
   localparam int CMD_W      = 32;
   localparam int LEN_MAX_W  = 16;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/seq_cmd_latch.sv
module seq_cmd_latch
   import spi_frame_seq_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CMD_W-1:0]  word,
   output logic [SEL_W-1:0]  sel_q,
   output logic              dual_q,
   output logic              txonly_q,
   output logic [SKIP_W-1:0] skip_q,
   output logic [LEN_W-1:0]  len_q
);

   logic unused_bits;
   assign unused_bits = ^{word[29], word[26:24], word[LEN_MAX_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         dual_q   <= 1'b0;
         txonly_q <= 1'b0;
         skip_q   <= '0;
         len_q    <= '0;
      end else if (load) begin
         sel_q    <= word[SEL_HI:SEL_LO];
         dual_q   <= word[DUAL_BIT];
         txonly_q <= word[TXONLY_BIT];
         skip_q   <= word[SKIP_HI:SKIP_LO];
         len_q    <= word[LEN_W-1:0];
      end
   end

endmodule

// File: rtl/seq_byte_ctr.sv
module seq_byte_ctr
   import spi_frame_seq_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [LEN_W-1:0]  len,
   input  logic [SKIP_W-1:0] skip,
   output logic              last,
   output logic              in_skip
);

   localparam int CW = (LEN_W > SKIP_W) ? LEN_W : SKIP_W;

   logic [LEN_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (clear) idx <= '0;
      else if (step)  idx <= idx + 1'b1;
   end

   assign last    = (idx == len);
   assign in_skip = (skip != '0) && (CW'(idx) < CW'(skip));

   // R3: the byte index never runs past the programmed length
   a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear) |=> (idx <= len));

endmodule

// File: rtl/seq_cs_drive.sv
module seq_cs_drive
   import spi_frame_seq_pkg::*;
#(
   parameter int NUM_CS = 4
) (
   input  logic              active,
   input  logic [SEL_W-1:0]  sel,
   output logic [NUM_CS-1:0] cs_n
);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_line
      assign cs_n[i] = !(active && (sel == SEL_W'(i)));
   end

endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
   import spi_frame_seq_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [31:0]       cmd_word,
   input  logic              tx_empty,
   input  logic              rx_full,
   input  logic              shift_done,
   output logic              busy,
   output logic [NUM_CS-1:0] cs_n,
   output logic              shift_go,
   output logic              tx_pop,
   output logic              tx_zero,
   output logic              rx_push,
   output logic              dual_o,
   output logic              done
);

   initial begin
      assert (NUM_CS >= 1 && NUM_CS <= (1 << SEL_W))
         else $error("NUM_CS out of range");
      assert (LEN_W >= 1 && LEN_W <= LEN_MAX_W)
         else $error("LEN_W out of range");
   end

   seq_state_e        state, state_nx;
   logic              accept;
   logic [SEL_W-1:0]  sel_q;
   logic              dual_q, txonly_q;
   logic [SKIP_W-1:0] skip_q;
   logic [LEN_W-1:0]  len_q;
   logic              last, in_skip;
   logic              skip_mode, need_tx, need_store, stall;
   logic              store_q;
   logic              byte_end;

   assign accept = (state == ST_IDLE) && cmd_valid;

   seq_cmd_latch #(.LEN_W(LEN_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .load(accept), .word(cmd_word),
      .sel_q(sel_q), .dual_q(dual_q), .txonly_q(txonly_q),
      .skip_q(skip_q), .len_q(len_q)
   );

   assign byte_end = (state == ST_WAIT) && shift_done;

   seq_byte_ctr #(.LEN_W(LEN_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clear(accept), .step(byte_end && !last),
      .len(len_q), .skip(skip_q), .last(last), .in_skip(in_skip)
   );

   assign busy = (state != ST_IDLE);

   seq_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
      .active(busy), .sel(sel_q), .cs_n(cs_n)
   );

   // per-byte source and sink decision
   assign skip_mode  = (skip_q != '0);
   assign need_tx    = !skip_mode || in_skip;
   assign need_store = skip_mode ? !in_skip : !txonly_q;
   assign stall      = (need_tx && tx_empty) || (need_store && rx_full);

   assign shift_go = (state == ST_ISSUE) && !stall;
   assign tx_pop   = shift_go && need_tx;
   assign tx_zero  = shift_go && !need_tx;
   assign rx_push  = byte_end && store_q;
   assign done     = byte_end && last;
   assign dual_o   = busy && dual_q && skip_mode && !in_skip;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:  if (cmd_valid) state_nx = ST_ISSUE;
         ST_ISSUE: if (!stall)    state_nx = ST_WAIT;
         ST_WAIT:  if (shift_done) state_nx = last ? ST_IDLE : ST_ISSUE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         store_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (shift_go) store_q <= need_store;
      end
   end

   // R9: transmit FIFO never popped while empty
   a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !tx_empty);

   // R10: a byte that must be kept never starts into a full receive FIFO
   a_r10_no_store_full: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_go && need_store) |-> !rx_full);

   // R2: at most one chip select active
   a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R2, R12: chip selects hold steady through a frame
   a_r12_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && $stable(cs_n)));

   // R11: frame ends right after done
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R7: exactly one data source per started byte
   a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      shift_go |-> (tx_pop != tx_zero));

   // R8: dual indication never during a popping byte
   a_r8_dual_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
      dual_o |-> (busy && !tx_pop));

   // R11: receive pushes only on a completion strobe
   a_r11_push_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> shift_done);

endmodule

// File: tb/spi_frame_seq_test.sv
module spi_frame_seq_test;

   localparam int NCS = 3;
   localparam int LW  = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmd_valid = 1'b0;
   logic [31:0]    cmd_word = '0;
   logic           tx_empty = 1'b0;
   logic           rx_full = 1'b0;
   logic           shift_done = 1'b0;
   logic           busy, shift_go, tx_pop, tx_zero, rx_push, dual_o, done;
   logic [NCS-1:0] cs_n;

   int checks = 0;
   int errors = 0;
   int wd_cycles = 0;

   spi_frame_seq #(.NUM_CS(NCS), .LEN_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .tx_empty(tx_empty), .rx_full(rx_full), .shift_done(shift_done),
      .busy(busy), .cs_n(cs_n), .shift_go(shift_go), .tx_pop(tx_pop),
      .tx_zero(tx_zero), .rx_push(rx_push), .dual_o(dual_o), .done(done)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      wd_cycles <= wd_cycles + 1;
      if (wd_cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL R11 watchdog: actual hung, expected frame completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_pops(int n, int l);
      if (n != 0) return (n < l) ? n : l;
      return l;
   endfunction

   function automatic int exp_stores(int n, int l, bit txonly);
      if (n != 0) return l - exp_pops(n, l);
      return txonly ? 0 : l;
   endfunction

   function automatic int exp_csn(int sel);
      if (sel < NCS) return ((1 << NCS) - 1) & ~(1 << sel);
      return (1 << NCS) - 1;
   endfunction

   task automatic run_frame(input int sel, input bit dual, input bit txonly,
                            input int skip, input int nbytes,
                            input int stall_pct, input bit intrude);
      int  n_go = 0, n_pop = 0, n_zero = 0, n_push = 0, n_done = 0;
      int  v_cs = 0, v_dual = 0, v_stall = 0, v_src = 0;
      int  cyc = 0, dly = 0;
      bit  in_flight = 0, finished = 0;
      logic [15:0] lenf;
      lenf = 16'(nbytes - 1);
      @(posedge clk); #1;
      cmd_word  = {sel[1:0], 1'b0, dual, txonly, 3'b000, skip[7:0], lenf};
      cmd_valid = 1'b1;
      while (!finished && cyc < 5000) begin
         @(negedge clk);
         if (busy && int'(cs_n) != exp_csn(sel)) v_cs++;
         if (shift_go) begin
            int  idx;
            bit  e_pop, e_store;
            idx     = n_go;
            e_pop   = (skip == 0) || (idx < skip);
            e_store = (skip != 0) ? (idx >= skip) : !txonly;
            n_go++;
            if (tx_pop)  n_pop++;
            if (tx_zero) n_zero++;
            if (tx_pop != e_pop || tx_zero == e_pop) v_src++;
            if ((e_pop && tx_empty) || (e_store && rx_full)) v_stall++;
            if (dual_o != (dual && skip != 0 && !e_pop)) v_dual++;
            in_flight = 1;
            dly = $urandom % 3;
         end
         if (rx_push) n_push++;
         if (done) begin
            n_done++;
            finished = 1;
         end
         if (!finished) begin
            @(posedge clk); #1;
            cmd_valid = (intrude && cyc == 3 && busy);
            if (cmd_valid)
               cmd_word = {2'(sel + 1), 1'b0, ~dual, ~txonly, 3'b000,
                           8'd2, 16'd5};
            shift_done = 1'b0;
            if (in_flight) begin
               if (dly == 0) begin
                  shift_done = 1'b1;
                  in_flight  = 0;
               end else dly--;
            end else rx_full = (($urandom % 100) < stall_pct);
            tx_empty = (($urandom % 100) < stall_pct);
            cyc++;
         end
      end
      @(posedge clk); #1;
      cmd_valid  = 1'b0;
      shift_done = 1'b0;
      @(negedge clk);
      chk("R3 byte starts", n_go, nbytes);
      chk((skip != 0) ? "R6 pops" : (txonly ? "R5 pops" : "R4 pops"),
          n_pop, exp_pops(skip, nbytes));
      chk("R7 zero bytes", n_zero, nbytes - exp_pops(skip, nbytes));
      chk((skip != 0) ? "R7 pushes" : (txonly ? "R5 pushes" : "R4 pushes"),
          n_push, exp_stores(skip, nbytes, txonly));
      chk("R6 per-byte source", v_src, 0);
      chk("R2 chip select", v_cs, 0);
      chk("R8 dual phase", v_dual, 0);
      chk("R9 R10 stall", v_stall, 0);
      chk("R11 done count", n_done, 1);
      chk("R11 idle after done", {busy, int'(cs_n)}, exp_csn(NCS));
      if (intrude) chk("R12 intruding command ignored", n_go + v_cs, nbytes);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 busy at reset", busy, 0);
      chk("R1 cs_n at reset", cs_n, 7);
      chk("R1 strobes at reset",
          {shift_go, tx_pop, tx_zero, rx_push, dual_o, done}, 0);
      rst_n = 1'b1;

      // directed corner cases
      run_frame(0, 0, 0, 0, 1,  0, 0);   // single byte, R4
      run_frame(1, 0, 0, 0, 64, 0, 0);   // max length, R3
      run_frame(2, 1, 0, 5, 12, 0, 0);   // skip + dual, R6 R7 R8
      run_frame(0, 1, 0, 0, 8,  0, 0);   // dual without skip, R8
      run_frame(1, 0, 1, 0, 9,  0, 0);   // transmit-only, R5
      run_frame(2, 0, 1, 4, 9,  0, 0);   // transmit-only ignored in skip, R6
      run_frame(0, 1, 0, 7, 7,  0, 0);   // skip equals length, R7
      run_frame(1, 0, 0, 200, 20, 0, 0); // skip beyond length, R7
      run_frame(3, 0, 0, 0, 6,  0, 0);   // unmatched select, R2
      run_frame(0, 0, 0, 3, 30, 60, 0);  // heavy stalls, R9 R10
      run_frame(1, 1, 0, 2, 15, 20, 1);  // command while busy, R12

      // constrained random frames
      for (int k = 0; k < 30; k++) begin
         int s, l;
         l = 1 + ($urandom % 64);
         s = ($urandom % 2) ? 0 : ($urandom % 12);
         run_frame($urandom % 4, $urandom % 2, $urandom % 2, s, l,
                   $urandom % 50, $urandom % 2);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
   end

endmodule